// File: doc/BRIEF.md
# Paged Multi-Channel Register Bank

This block stores the control registers of a four-channel device behind one 8-bit register address space. It holds one shared register set and four per-channel register sets. The top address, 0xFF, is a write-only page register that steers every other access. It can route an access to the shared set or to one chosen channel set. In broadcast mode a write goes to all four channel sets at once, while reads still come from a single channel.

A host drives a simple synchronous port: an address, write data, a write strobe and a read strobe. Read data comes back registered, one clock after the read strobe. Only addresses below the `NREG` parameter have storage in each set. A page value with any of the upper four bits set is stored truncated, and a sticky error flag is raised.

Top module: `paged_regbank`

## Requirements
- R1: After reset the page register is 0x00, every shared and channel location holds zero, `sel_err` is 0 and `rdata` is 0.
- R2: While page bit 2 is 0, a write at an address below NREG updates only the shared location at that address, and a read returns that shared location.
- R3: While page bit 2 is 1, an access below NREG goes to the channel set numbered by page bits 1:0 (0 to 3) at the same address. The shared set is left unchanged.
- R4: While page bits 3 and 2 are both 1, a write below NREG updates that address in all four channel sets in the same cycle. Reads still come only from the channel numbered by bits 1:0.
- R5: Page bit 3 has no effect while bit 2 is 0. A page value of 0x08 targets the shared set exactly as 0x00 does.
- R6: A write to address 0xFF always loads page bits 3:0 from write data bits 3:0, whatever the current page. It alters no shared or channel location.
- R7: A read of address 0xFF returns 0x00.
- R8: A write to 0xFF with any of data bits 7:4 set stores only bits 3:0 and sets `sel_err`. `sel_err` then stays 1 until reset.
- R9: `rdata` is loaded on the clock edge that samples `rd` and uses the page in force before that edge. It holds its value while `rd` is 0.
- R10: Addresses from NREG to 0xFE have no storage. Reads there return 0x00 and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Register address |
| wdata | input | DW | Write data |
| wr | input | 1 | Write strobe, one access per cycle |
| rd | input | 1 | Read strobe |
| rdata | output | DW | Registered read data |
| sel_err | output | 1 | Sticky flag: page written with nonzero upper nibble |

## Verification
The bench builds the block with DW = 8 and NREG = 16. With only 16 backed locations, an unbacked address such as 0x20 is reachable. It aliases location 0 in its low bits, so the test can show that unbacked accesses neither store nor alias. The select address 0xFF also aliases location 15 in its low four bits, so the bench can check that page writes leave location 15 untouched in every set. The bench covers all four channels, broadcast with each read channel, and a page write in the same cycle as a read.

// File: rtl/paged_regbank.sv
module paged_regbank #(
  parameter int DW   = 8,
  parameter int NREG = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr,
  input  logic          rd,
  output logic [DW-1:0] rdata,
  output logic          sel_err
);
  localparam int NCH = 4;
  localparam int IW  = $clog2(NREG);
  localparam logic [7:0] SEL_ADDR = 8'hFF;

  logic [3:0]    page_q;
  logic [DW-1:0] shr [NREG];
  logic [DW-1:0] chn [NCH][NREG];

  wire          is_sel  = (addr == SEL_ADDR);
  wire          in_rng  = !is_sel && (int'(addr) < NREG);
  wire [IW-1:0] idx     = addr[IW-1:0];
  wire          chan_en = page_q[2];
  wire          bcast   = page_q[3] & page_q[2];
  wire [1:0]    ch      = page_q[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      sel_err <= 1'b0;
      rdata   <= '0;
      for (int r = 0; r < NREG; r++) begin
        shr[r] <= '0;
        for (int c = 0; c < NCH; c++) chn[c][r] <= '0;
      end
    end else begin
      if (wr) begin
        if (is_sel) begin
          page_q <= wdata[3:0];
          if (|wdata[7:4]) sel_err <= 1'b1;
        end else if (in_rng) begin
          if (!chan_en) shr[idx] <= wdata;
          else
            for (int c = 0; c < NCH; c++)
              if (bcast || (2'(c) == ch)) chn[c][idx] <= wdata;
        end
      end
      if (rd) begin
        if (!in_rng)      rdata <= '0;
        else if (chan_en) rdata <= chn[ch][idx];
        else              rdata <= shr[idx];
      end
    end
  end

  // R6
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && is_sel |=> page_q == $past(wdata[3:0]));

  // R7
  sel_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd && is_sel |=> rdata == '0);

  // R8
  sel_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && is_sel && (|wdata[7:4]) |=> sel_err);

  // R8
  sel_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err |=> sel_err);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  // R3
  shared_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && in_rng && chan_en |=> shr[$past(idx)] == $past(shr[idx]));

  // R4
  bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && in_rng && bcast |=>
      chn[0][$past(idx)] == $past(wdata) && chn[1][$past(idx)] == $past(wdata) &&
      chn[2][$past(idx)] == $past(wdata) && chn[3][$past(idx)] == $past(wdata));
endmodule

// File: tb/paged_regbank_bench.sv
module paged_regbank_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] addr = 0;
  logic [7:0] wdata = 0;
  logic       wr = 0;
  logic       rd = 0;
  logic [7:0] rdata;
  logic       sel_err;
  int checks = 0;
  int errors = 0;

  paged_regbank #(.DW(8), .NREG(16)) u_paged_regbank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .rdata(rdata), .sel_err(sel_err));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1;
    @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    do_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 sel_err", {7'd0, sel_err}, 8'h00);
    rd_chk("R1 shared", 8'h03, 8'h00);
    do_wr(8'hFF, 8'h07);
    rd_chk("R1 channel", 8'h03, 8'h00);
    do_wr(8'hFF, 8'h00);
  endtask

  task automatic t_shared;
    do_wr(8'h02, 8'hA5);
    rd_chk("R2 shared rd", 8'h02, 8'hA5);
    do_wr(8'hFF, 8'h04);
    rd_chk("R2 ch0 untouched", 8'h02, 8'h00);
    do_wr(8'hFF, 8'h00);
  endtask

  task automatic t_channel;
    do_wr(8'hFF, 8'h05);
    do_wr(8'h02, 8'h51);
    do_wr(8'hFF, 8'h06);
    rd_chk("R3 ch2 untouched", 8'h02, 8'h00);
    do_wr(8'hFF, 8'h05);
    rd_chk("R3 ch1 rd", 8'h02, 8'h51);
    do_wr(8'hFF, 8'h00);
    rd_chk("R3 shared kept", 8'h02, 8'hA5);
  endtask

  task automatic t_bcast;
    do_wr(8'hFF, 8'h0E);
    do_wr(8'h07, 8'h3C);
    rd_chk("R4 ch2", 8'h07, 8'h3C);
    for (int c = 0; c < 4; c++) begin
      do_wr(8'hFF, 8'h04 | 8'(c));
      rd_chk("R4 each ch", 8'h07, 8'h3C);
    end
    do_wr(8'hFF, 8'h0D);
    rd_chk("R4 read ch1 only", 8'h02, 8'h51);
    do_wr(8'hFF, 8'h0F);
    rd_chk("R4 read ch3 only", 8'h02, 8'h00);
    do_wr(8'hFF, 8'h00);
    rd_chk("R4 shared kept", 8'h07, 8'h00);
  endtask

  task automatic t_bit3only;
    do_wr(8'hFF, 8'h08);
    do_wr(8'h04, 8'h77);
    rd_chk("R5 rd as shared", 8'h04, 8'h77);
    do_wr(8'hFF, 8'h00);
    rd_chk("R5 shared", 8'h04, 8'h77);
    do_wr(8'hFF, 8'h0C);
    rd_chk("R5 ch0 clear", 8'h04, 8'h00);
    do_wr(8'hFF, 8'h00);
  endtask

  task automatic t_selwrite;
    do_wr(8'hFF, 8'h0F);
    do_wr(8'hFF, 8'h04);
    do_wr(8'h02, 8'h40);
    rd_chk("R6 ch0 written", 8'h02, 8'h40);
    do_wr(8'hFF, 8'h05);
    rd_chk("R6 ch1 kept", 8'h02, 8'h51);
    do_wr(8'hFF, 8'h00);
    rd_chk("R6 shared loc15", 8'h0F, 8'h00);
    for (int c = 0; c < 4; c++) begin
      do_wr(8'hFF, 8'h04 | 8'(c));
      rd_chk("R6 channel loc15", 8'h0F, 8'h00);
    end
    do_wr(8'hFF, 8'h00);
  endtask

  task automatic t_ffread;
    do_wr(8'hFF, 8'h0F);
    rd_chk("R7 read FF", 8'hFF, 8'h00);
    do_wr(8'hFF, 8'h00);
    rd_chk("R7 read FF shared", 8'hFF, 8'h00);
  endtask

  task automatic t_err;
    chk("R8 clear before", {7'd0, sel_err}, 8'h00);
    do_wr(8'hFF, 8'h35);
    chk("R8 set", {7'd0, sel_err}, 8'h01);
    rd_chk("R8 low bits kept", 8'h02, 8'h51);
    do_wr(8'hFF, 8'h00);
    chk("R8 sticky", {7'd0, sel_err}, 8'h01);
  endtask

  task automatic t_timing;
    logic [7:0] v;
    do_wr(8'hFF, 8'h05);
    do_rd(8'h02, v);
    repeat (3) @(negedge clk);
    chk("R9 hold", rdata, 8'h51);
    @(negedge clk); addr = 8'h02; rd = 1;
    @(posedge clk); #1;
    chk("R9 one clock", rdata, 8'h51);
    @(negedge clk); rd = 0;
    do_wr(8'hFF, 8'h00);
    rd_chk("R9 shared", 8'h02, 8'hA5);
    do_wr(8'hFF, 8'h05);
    @(negedge clk); addr = 8'hFF; wdata = 8'h00; wr = 1; rd = 1;
    @(negedge clk); wr = 0; rd = 0;
    chk("R9 FF same cycle", rdata, 8'h00);
    @(negedge clk); addr = 8'h02; rd = 1;
    @(negedge clk); rd = 0;
    chk("R9 new page", rdata, 8'hA5);
  endtask

  task automatic t_range;
    do_wr(8'h00, 8'h11);
    do_wr(8'h20, 8'h99);
    rd_chk("R10 read unbacked", 8'h20, 8'h00);
    rd_chk("R10 no alias", 8'h00, 8'h11);
    rd_chk("R10 top unbacked", 8'hFE, 8'h00);
  endtask

  task automatic t_rereset;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 err cleared", {7'd0, sel_err}, 8'h00);
    rd_chk("R1 shared cleared", 8'h02, 8'h00);
    do_wr(8'hFF, 8'h05);
    rd_chk("R1 ch1 cleared", 8'h02, 8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_shared();
    t_channel();
    t_bcast();
    t_bit3only();
    t_selwrite();
    t_ffread();
    t_err();
    t_timing();
    t_range();
    t_rereset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule